// File: doc/BRIEF.md
# Dual Converter Status and Result Registers

This block sits on an 8-bit special-function-register bus between a microcontroller and two converter cores: a 24-bit primary channel and a 16-bit auxiliary channel. Each core reports the end of a conversion or calibration with a one-cycle completion pulse. The pulse carries a value and two range flags. The block stores that value in byte-wide data, offset or gain registers, depending on what the channel was doing. It also keeps a shared status byte and a mode register. Software starts a conversion or a calibration by writing the mode register.

Each channel runs a small state machine with four states, and the states use the same codes as the mode field. `CH_IDLE` (00) ignores completions. `CH_CONV` (01) converts continuously and stays in that state after each accepted result. `CH_CALOFS` (10) captures the offset coefficient. `CH_CALGAIN` (11) captures the gain coefficient. There are three transitions:
- A mode write moves a channel into the state coded by its mode field. This transition has priority over everything else.
- An accepted completion in `CH_CALOFS` or `CH_CALGAIN` returns the channel to `CH_IDLE`.
- In every other case the channel holds its state.

A completion is accepted only when three things hold: the channel is not idle, its ready flag is clear, and no mode write happens in the same cycle. This means software must acknowledge a result before the next one can replace it.

Top module: `dual_adc_regs`

## Requirements
- R1: After reset, the status byte, the mode register and every data, offset and gain byte read 0x00.
- R2: The status byte at address 0xD8 holds, from bit 7 down to bit 0: RDY0 (primary ready), RDY1 (auxiliary ready), CAL, NOXREF, ERR0, ERR1, 0, 0.
- R3: The mode register at address 0xD1 uses these fields: bits 1:0 set the primary mode, bits 3:2 set the auxiliary mode, and bit 4 selects the external reference. The mode codes are 00 idle, 01 convert, 10 offset calibration and 11 gain calibration. An accepted completion in convert mode stores the value in the primary data bytes (0xD9 low, 0xDA middle, 0xDB high) and sets RDY0. The channel stays in convert mode.
- R4: A completion that arrives while the channel's RDY bit is set is discarded. The stored registers and the status byte stay unchanged, and this includes back-to-back pulses.
- R5: A write to the status byte clears RDY0 when bit 7 of the written byte is 0, and clears RDY1 when bit 6 is 0. Writing a 1 to either bit has no effect, and the other bits of the written byte are ignored.
- R6: A mode write with a nonzero code for a channel clears that channel's RDY and ERR bits and clears CAL. Code 00 stops the channel without clearing any flag. A completion in the same cycle as a mode write is dropped.
- R7: If a conversion completes with the over-range flag set, the stored result is all ones. If it completes with the under-range flag set, the stored result is all zeros. In both cases the channel's ERR bit is set. ERR bits are cleared only by a mode write that starts the channel.
- R8: An accepted calibration completion sets RDY and CAL and returns the channel to idle. If no range flag is set, the value is stored in the offset bytes (primary 0xE1 to 0xE3, auxiliary 0xE4 and 0xE5) or in the gain bytes (primary 0xE9 to 0xEB, auxiliary 0xEC and 0xED). If a range flag is set, the coefficient is left unchanged and ERR is set.
- R9: NOXREF reads 1 while the reference-good input is low and at least one channel is not idle. While NOXREF is 1 and the external reference is selected, accepted results are forced to all ones and ERR is set.
- R10: A completion pulse to an idle channel has no effect.
- R11: Reads have no side effects, and addresses that are not mapped read 0x00.
- R12: An accepted auxiliary conversion stores 16 bits in the auxiliary data bytes (0xDC low, 0xDD high) and sets RDY1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr (combinational) |
| ref_ok | input | 1 | High when the reference voltage is present |
| p_done | input | 1 | Primary completion pulse |
| p_data | input | 24 | Primary completion value |
| p_ovr | input | 1 | Primary over-range flag |
| p_udr | input | 1 | Primary under-range flag |
| a_done | input | 1 | Auxiliary completion pulse |
| a_data | input | 16 | Auxiliary completion value |
| a_ovr | input | 1 | Auxiliary over-range flag |
| a_udr | input | 1 | Auxiliary under-range flag |

## Verification
An error in a channel's state or in its ready flag becomes visible at the ports on the first read after the next completion pulse. The pulse is either captured when it should have been dropped, or dropped when it should have been captured. If a flag update is wrong, the status byte shows it from the clock edge after the write or pulse that caused it. A wrong clamp or forcing decision appears in the data bytes one cycle after the pulse that triggers it. Because of this, every completion in the sequence is followed by reads of both the status byte and the affected result bytes.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;
    localparam int PRI_W = 24;
    localparam int AUX_W = 16;

    localparam logic [7:0] A_MODE  = 8'hD1;
    localparam logic [7:0] A_STAT  = 8'hD8;
    localparam logic [7:0] A_PDAT  = 8'hD9;
    localparam logic [7:0] A_ADAT  = 8'hDC;
    localparam logic [7:0] A_POFS  = 8'hE1;
    localparam logic [7:0] A_AOFS  = 8'hE4;
    localparam logic [7:0] A_PGN   = 8'hE9;
    localparam logic [7:0] A_AGN   = 8'hEC;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'b00,
        CH_CONV    = 2'b01,
        CH_CALOFS  = 2'b10,
        CH_CALGAIN = 2'b11
    } chan_state_t;
endpackage

// File: rtl/adc_chan.sv
module adc_chan
    import adcreg_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr_i,
    input  logic [1:0]   mode_i,
    input  logic         clr_rdy_i,
    input  logic         done_i,
    input  logic [W-1:0] data_i,
    input  logic         ovr_i,
    input  logic         udr_i,
    input  logic         force_ones_i,
    output logic         rdy_o,
    output logic         err_o,
    output logic         cal_done_o,
    output logic         active_o,
    output logic [W-1:0] dat_o,
    output logic [W-1:0] ofs_o,
    output logic [W-1:0] gain_o
);
    chan_state_t  state_q, state_d;
    logic         rdy_q, err_q;
    logic [W-1:0] dat_q, ofs_q, gain_q;
    logic         accept, clamp, is_cal;
    logic [W-1:0] res;

    assign is_cal = (state_q == CH_CALOFS) || (state_q == CH_CALGAIN);
    assign accept = done_i && !rdy_q && !mode_wr_i && (state_q != CH_IDLE);
    assign clamp  = force_ones_i || ovr_i || udr_i;
    assign res    = (force_ones_i || ovr_i) ? {W{1'b1}} :
                    udr_i ? {W{1'b0}} : data_i;

    always_comb begin
        state_d = state_q;
        if (mode_wr_i)
            state_d = chan_state_t'(mode_i);
        else if (accept && is_cal)
            state_d = CH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            dat_q  <= '0;
            ofs_q  <= '0;
            gain_q <= '0;
        end else if (mode_wr_i) begin
            if (mode_i != CH_IDLE) begin
                rdy_q <= 1'b0;
                err_q <= 1'b0;
            end
        end else begin
            if (clr_rdy_i) rdy_q <= 1'b0;
            if (accept) begin
                rdy_q <= 1'b1;
                if (clamp) err_q <= 1'b1;
                unique case (state_q)
                    CH_CONV:    dat_q <= res;
                    CH_CALOFS:  if (!clamp) ofs_q <= res;
                    CH_CALGAIN: if (!clamp) gain_q <= res;
                    default:    ;
                endcase
            end
        end
    end

    assign rdy_o      = rdy_q;
    assign err_o      = err_q;
    assign cal_done_o = accept && is_cal;
    assign active_o   = (state_q != CH_IDLE);
    assign dat_o      = dat_q;
    assign ofs_o      = ofs_q;
    assign gain_o     = gain_q;

    // R4
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !mode_wr_i) |=> ($stable(dat_q) && $stable(ofs_q) && $stable(gain_q)));

    // R6
    mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_i != 2'b00) |=> (!rdy_q && !err_q));

    // R7
    clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_CONV && done_i && !rdy_q && !mode_wr_i && ovr_i)
        |=> (dat_q == {W{1'b1}} && err_q && rdy_q));

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !mode_wr_i)
        |=> ($stable(dat_q) && $stable(ofs_q) && $stable(gain_q)));
endmodule

// File: rtl/adc_rdmux.sv
module adc_rdmux
    import adcreg_pkg::*;
(
    input  logic [7:0]       addr_i,
    input  logic [7:0]       stat_i,
    input  logic [7:0]       mode_i,
    input  logic [PRI_W-1:0] p_dat_i,
    input  logic [PRI_W-1:0] p_ofs_i,
    input  logic [PRI_W-1:0] p_gain_i,
    input  logic [AUX_W-1:0] a_dat_i,
    input  logic [AUX_W-1:0] a_ofs_i,
    input  logic [AUX_W-1:0] a_gain_i,
    output logic [7:0]       rdata_o
);
    always_comb begin
        case (addr_i)
            A_STAT:     rdata_o = stat_i;
            A_MODE:     rdata_o = mode_i;
            A_PDAT:     rdata_o = p_dat_i[7:0];
            A_PDAT + 1: rdata_o = p_dat_i[15:8];
            A_PDAT + 2: rdata_o = p_dat_i[23:16];
            A_ADAT:     rdata_o = a_dat_i[7:0];
            A_ADAT + 1: rdata_o = a_dat_i[15:8];
            A_POFS:     rdata_o = p_ofs_i[7:0];
            A_POFS + 1: rdata_o = p_ofs_i[15:8];
            A_POFS + 2: rdata_o = p_ofs_i[23:16];
            A_AOFS:     rdata_o = a_ofs_i[7:0];
            A_AOFS + 1: rdata_o = a_ofs_i[15:8];
            A_PGN:      rdata_o = p_gain_i[7:0];
            A_PGN + 1:  rdata_o = p_gain_i[15:8];
            A_PGN + 2:  rdata_o = p_gain_i[23:16];
            A_AGN:      rdata_o = a_gain_i[7:0];
            A_AGN + 1:  rdata_o = a_gain_i[15:8];
            default:    rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/dual_adc_regs.sv
module dual_adc_regs
    import adcreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              ref_ok,
    input  logic              p_done,
    input  logic [PRI_W-1:0]  p_data,
    input  logic              p_ovr,
    input  logic              p_udr,
    input  logic              a_done,
    input  logic [AUX_W-1:0]  a_data,
    input  logic              a_ovr,
    input  logic              a_udr
);
    logic [4:0]       mode_q;
    logic             cal_q;
    logic             mode_wr, stat_wr, any_start, noxref, force_ones;
    logic             rdy0, rdy1, err0, err1, cdone0, cdone1, act0, act1;
    logic [PRI_W-1:0] p_dat, p_ofs, p_gain;
    logic [AUX_W-1:0] a_dat, a_ofs, a_gain;
    logic [7:0]       stat_byte;

    assign mode_wr    = sfr_wr && (sfr_addr == A_MODE);
    assign stat_wr    = sfr_wr && (sfr_addr == A_STAT);
    assign any_start  = mode_wr && (sfr_wdata[1:0] != 2'b00 || sfr_wdata[3:2] != 2'b00);
    assign noxref     = !ref_ok && (act0 || act1);
    assign force_ones = noxref && mode_q[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            cal_q  <= 1'b0;
        end else begin
            if (mode_wr) mode_q <= sfr_wdata[4:0];
            if (any_start)                 cal_q <= 1'b0;
            else if (cdone0 || cdone1)     cal_q <= 1'b1;
        end
    end

    adc_chan #(.W(PRI_W)) u_pri (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_i(mode_wr), .mode_i(sfr_wdata[1:0]),
        .clr_rdy_i(stat_wr && !sfr_wdata[7]),
        .done_i(p_done), .data_i(p_data), .ovr_i(p_ovr), .udr_i(p_udr),
        .force_ones_i(force_ones),
        .rdy_o(rdy0), .err_o(err0), .cal_done_o(cdone0), .active_o(act0),
        .dat_o(p_dat), .ofs_o(p_ofs), .gain_o(p_gain)
    );

    adc_chan #(.W(AUX_W)) u_aux (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_i(mode_wr), .mode_i(sfr_wdata[3:2]),
        .clr_rdy_i(stat_wr && !sfr_wdata[6]),
        .done_i(a_done), .data_i(a_data), .ovr_i(a_ovr), .udr_i(a_udr),
        .force_ones_i(force_ones),
        .rdy_o(rdy1), .err_o(err1), .cal_done_o(cdone1), .active_o(act1),
        .dat_o(a_dat), .ofs_o(a_ofs), .gain_o(a_gain)
    );

    assign stat_byte = {rdy0, rdy1, cal_q, noxref, err0, err1, 2'b00};

    adc_rdmux u_rd (
        .addr_i(sfr_addr), .stat_i(stat_byte), .mode_i({3'b000, mode_q}),
        .p_dat_i(p_dat), .p_ofs_i(p_ofs), .p_gain_i(p_gain),
        .a_dat_i(a_dat), .a_ofs_i(a_ofs), .a_gain_i(a_gain),
        .rdata_o(sfr_rdata)
    );

    // R6
    cal_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !cal_q);

    // R5
    swclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !sfr_wdata[7] && rdy0) |=> !rdy0);

    // R8
    cal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_start && (cdone0 || cdone1)) |=> cal_q);
endmodule

// File: tb/test_dual_adc_regs.sv
`timescale 1ns/1ps
module test_dual_adc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        ref_ok = 1'b1;
    logic        p_done = 1'b0, p_ovr = 1'b0, p_udr = 1'b0;
    logic [23:0] p_data = '0;
    logic        a_done = 1'b0, a_ovr = 1'b0, a_udr = 1'b0;
    logic [15:0] a_data = '0;
    int          tests = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    dual_adc_regs i_dual_adc_regs (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ref_ok(ref_ok),
        .p_done(p_done), .p_data(p_data), .p_ovr(p_ovr), .p_udr(p_udr),
        .a_done(a_done), .a_data(a_data), .a_ovr(a_ovr), .a_udr(a_udr)
    );

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_DN = 2'd2, K_RF = 2'd3;
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [7:0]  bv;
        logic [23:0] val;
        logic        ch;
        logic        ovr;
        logic        udr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        '{K_WR, 8'hD1, 8'h05, 24'h0,      1'b0, 1'b0, 1'b0, 4'd3},  // R3 both convert
        '{K_DN, 8'h00, 8'h00, 24'h123456, 1'b0, 1'b0, 1'b0, 4'd3},
        '{K_RD, 8'hD8, 8'h80, 24'h0,      1'b0, 1'b0, 1'b0, 4'd2},  // R2 RDY0 at bit 7
        '{K_RD, 8'hD9, 8'h56, 24'h0,      1'b0, 1'b0, 1'b0, 4'd3},
        '{K_RD, 8'hDA, 8'h34, 24'h0,      1'b0, 1'b0, 1'b0, 4'd3},
        '{K_RD, 8'hDB, 8'h12, 24'h0,      1'b0, 1'b0, 1'b0, 4'd3},
        '{K_DN, 8'h00, 8'h00, 24'hAAAAAA, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 inhibited
        '{K_RD, 8'hDB, 8'h12, 24'h0,      1'b0, 1'b0, 1'b0, 4'd4},
        '{K_RD, 8'hD8, 8'h80, 24'h0,      1'b0, 1'b0, 1'b0, 4'd4},
        '{K_DN, 8'h00, 8'h00, 24'h00BEEF, 1'b1, 1'b0, 1'b0, 4'd12}, // R12 aux
        '{K_RD, 8'hDC, 8'hEF, 24'h0,      1'b0, 1'b0, 1'b0, 4'd12},
        '{K_RD, 8'hDD, 8'hBE, 24'h0,      1'b0, 1'b0, 1'b0, 4'd12},
        '{K_RD, 8'hD8, 8'hC0, 24'h0,      1'b0, 1'b0, 1'b0, 4'd12},
        '{K_WR, 8'hD8, 8'h40, 24'h0,      1'b0, 1'b0, 1'b0, 4'd5},  // R5 clear RDY0 only
        '{K_RD, 8'hD8, 8'h40, 24'h0,      1'b0, 1'b0, 1'b0, 4'd5},
        '{K_DN, 8'h00, 8'h00, 24'h000001, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 over-range
        '{K_RD, 8'hDB, 8'hFF, 24'h0,      1'b0, 1'b0, 1'b0, 4'd7},
        '{K_RD, 8'hD9, 8'hFF, 24'h0,      1'b0, 1'b0, 1'b0, 4'd7},
        '{K_RD, 8'hD8, 8'hC8, 24'h0,      1'b0, 1'b0, 1'b0, 4'd7},
        '{K_WR, 8'hD8, 8'h3F, 24'h0,      1'b0, 1'b0, 1'b0, 4'd5},  // R5 other bits ignored
        '{K_RD, 8'hD8, 8'h08, 24'h0,      1'b0, 1'b0, 1'b0, 4'd5},
        '{K_DN, 8'h00, 8'h00, 24'h654321, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 under-range
        '{K_RD, 8'hDB, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd7},
        '{K_RD, 8'hD8, 8'h88, 24'h0,      1'b0, 1'b0, 1'b0, 4'd7},
        '{K_WR, 8'hD1, 8'h06, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},  // R6 start clears
        '{K_RD, 8'hD8, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},
        '{K_DN, 8'h00, 8'h00, 24'h000111, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 offset cal
        '{K_RD, 8'hE1, 8'h11, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RD, 8'hE2, 8'h01, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RD, 8'hE3, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RD, 8'hD8, 8'hA0, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_DN, 8'h00, 8'h00, 24'h999999, 1'b0, 1'b0, 1'b0, 4'd8},
        '{K_WR, 8'hD8, 8'h7F, 24'h0,      1'b0, 1'b0, 1'b0, 4'd5},
        '{K_RD, 8'hD8, 8'h20, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},  // R8 CAL survives
        '{K_RD, 8'hE1, 8'h11, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_DN, 8'h00, 8'h00, 24'h777777, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 idle
        '{K_RD, 8'hD8, 8'h20, 24'h0,      1'b0, 1'b0, 1'b0, 4'd10},
        '{K_RD, 8'hD9, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd10},
        '{K_WR, 8'hD1, 8'h07, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},  // R6 clears CAL
        '{K_RD, 8'hD8, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},
        '{K_DN, 8'h00, 8'h00, 24'h424242, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 failed gain cal
        '{K_RD, 8'hD8, 8'hA8, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RD, 8'hE9, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RD, 8'hEB, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd8},
        '{K_RF, 8'h00, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},  // R9 reference lost
        '{K_RD, 8'hD8, 8'hB8, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_WR, 8'hD1, 8'h15, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_RD, 8'hD8, 8'h10, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_DN, 8'h00, 8'h00, 24'h001234, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 forced ones
        '{K_RD, 8'hDC, 8'hFF, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_RD, 8'hDD, 8'hFF, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_RD, 8'hD8, 8'h54, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_RF, 8'h00, 8'h00, 24'h1,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_RD, 8'hD8, 8'h44, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},
        '{K_WR, 8'hD1, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},  // R6 stop keeps flags
        '{K_RD, 8'hD8, 8'h44, 24'h0,      1'b0, 1'b0, 1'b0, 4'd6},
        '{K_RF, 8'h00, 8'h00, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9},  // R9 idle: no NOXREF
        '{K_RD, 8'hD8, 8'h44, 24'h0,      1'b0, 1'b0, 1'b0, 4'd9}
    };

    task automatic chk(input logic [7:0] a, input logic [7:0] exp, input int r);
        @(negedge clk);
        sfr_addr = a;
        #1;
        tests++;
        if (sfr_rdata !== exp) begin
            fails++;
            $display("FAIL R%0d addr %h actual %h expected %h", r, a, sfr_rdata, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic pulse(input logic ch, input logic [23:0] v, input logic o, input logic u);
        @(negedge clk);
        if (ch) begin a_done = 1'b1; a_data = v[15:0]; a_ovr = o; a_udr = u; end
        else    begin p_done = 1'b1; p_data = v;       p_ovr = o; p_udr = u; end
        @(negedge clk);
        p_done = 1'b0; a_done = 1'b0; p_ovr = 1'b0; p_udr = 1'b0; a_ovr = 1'b0; a_udr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk(8'hD8, 8'h00, 1);
        chk(8'hD1, 8'h00, 1);
        chk(8'hDB, 8'h00, 1);
        chk(8'hE3, 8'h00, 1);
        chk(8'hED, 8'h00, 1);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].kind)
                K_WR: wr(VEC[i].addr, VEC[i].bv);
                K_RD: chk(VEC[i].addr, VEC[i].bv, int'(VEC[i].req));
                K_DN: pulse(VEC[i].ch, VEC[i].val, VEC[i].ovr, VEC[i].udr);
                default: begin @(negedge clk); ref_ok = VEC[i].val[0]; end
            endcase
        end
        @(negedge clk); ref_ok = 1'b1;

        // R11 unmapped and repeated reads
        chk(8'h00, 8'h00, 11);
        chk(8'hD1, 8'h00, 11);
        chk(8'hDC, 8'hFF, 11);
        chk(8'hDC, 8'hFF, 11);

        // R6 completion in the same cycle as a starting mode write is dropped
        @(negedge clk);
        sfr_addr = 8'hD1; sfr_wdata = 8'h01; sfr_wr = 1'b1;
        p_done = 1'b1; p_data = 24'h5A5A5A;
        @(negedge clk);
        sfr_wr = 1'b0; p_done = 1'b0;
        chk(8'hD9, 8'h00, 6);
        chk(8'hD8, 8'h44, 6);
        pulse(1'b0, 24'h5A5A5A, 1'b0, 1'b0);
        chk(8'hD9, 8'h5A, 3);
        chk(8'hD8, 8'hC4, 3);

        // R4 back-to-back completions: only the first one lands
        wr(8'hD8, 8'h3F);
        chk(8'hD8, 8'h04, 5);
        @(negedge clk);
        p_done = 1'b1; p_data = 24'h010203;
        @(negedge clk);
        p_data = 24'h040506;
        @(negedge clk);
        p_done = 1'b0;
        chk(8'hD9, 8'h03, 4);
        chk(8'hD8, 8'h84, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule